// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block walks a small ring of transmit descriptors kept in a word-wide memory and turns each ready descriptor into a byte stream for a MAC transmitter. Software prepares descriptors, sets their ready bits and then writes the demand register. The engine polls the current descriptor and streams its buffer. When the MAC reports the outcome, the engine writes the completion status back into the descriptor and clears the ready bit. It then moves on to the next descriptor.

Polling stops at the first descriptor that is not ready. The engine then stays idle until the next demand write. If the MAC reports a failure, the engine raises an error event and halts. It does not fetch again until a restart command arrives. Each frame carries two options from its descriptor: pad short frames, and append CRC.

Top module: `txr_engine`

## Requirements
- R1: After synchronous reset, `mem_rd`, `mem_wr`, `tx_valid` and every bit of `evt` are low.
- R2: A write on `dmd_wr` with `dmd_data[15]` set makes the engine read word 0 of the current descriptor. A write with `dmd_data[15]` clear causes no memory access and no stream output.
- R3: Descriptor i occupies memory word `DESC_BASE+2i` and the word after it. Word 0 holds the status in bits 31:16 and the byte length in bits 15:0. Word 1 holds the buffer's starting word address. Status bit 15 is ready. A descriptor without ready ends polling, and the engine does not touch memory again until a new demand.
- R4: A ready descriptor's bytes are sent one per `tx_valid`/`tx_ready` handshake, in order. Each buffer word supplies bytes from bits 7:0 upward, and exactly `length` bytes are sent. `tx_last` marks the final byte. `tx_pad` equals status bit 14 and `tx_crc` equals status bit 10 for every byte of the frame.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_last`, `tx_pad` and `tx_crc` hold their values.
- R6: After `mac_done`, word 0 is rewritten with the length unchanged, ready cleared and all other status bits kept. The error bits 9,8,7,6,1,0 are replaced by `mac_err[5:0]` in that order (deferred, heartbeat, late collision, retry limit, underrun, carrier lost). A clean outcome pulses `evt[1]` for one cycle in the write-back cycle.
- R7: After a clean completion the engine polls the next descriptor at once. The index returns to 0 after the last ring entry (NDESC-1) or after a descriptor whose status bit 13 (wrap) is set.
- R8: A nonzero `mac_err` pulses `evt[4]` instead of `evt[1]` and advances the index. The engine then halts: no memory access or stream output takes place, and demand writes are discarded. A `restart` pulse resumes polling at the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmd_wr | input | 1 | Demand register write strobe |
| dmd_data | input | 16 | Demand register write data; bit 15 requests a poll |
| restart | input | 1 | Restart command pulse, leaves the halted state |
| mem_rd | output | 1 | Memory read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_pad | output | 1 | Pad-short-frame option of the frame |
| tx_crc | output | 1 | Append-CRC option of the frame |
| mac_done | input | 1 | MAC reports that the frame is finished |
| mac_err | input | 6 | MAC failure flags, valid with `mac_done` |
| evt | output | 5 | Event pulses: bit 1 frame sent, bit 4 transmit error |

## Verification
Two things can meet in one cycle: the write-back of a descriptor with an error event, and the halt that follows it. The bench sets up one failing frame followed by a ready descriptor. It then checks that the failing descriptor is closed with its error bits and the next descriptor is left untouched. A demand write during the halt must produce no memory reads, and only the restart pulse may release the waiting frame. A second overlap is a demand write arriving while the stream is stalled by `tx_ready`. The bench provokes this with a MAC that stalls on a fixed pattern and checks that every byte still arrives once, in order, with unchanged options.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int STAT_W  = 16;
    localparam int B_READY = 15;
    localparam int B_PAD   = 14;
    localparam int B_WRAP  = 13;
    localparam int B_CRC   = 10;
    localparam logic [STAT_W-1:0] ERR_MASK = 16'h03C3;

    localparam int EV_W    = 5;
    localparam int EV_SENT = 1;
    localparam int EV_ERR  = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_D0, S_D0W, S_D1, S_D1W, S_BR, S_BRW, S_OUT, S_WAIT, S_WB, S_HALT
    } state_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [15:0]       len;
    } desc_w0_t;

    typedef struct packed {
        logic def;
        logic hb;
        logic lc;
        logic rl;
        logic un;
        logic csl;
    } mac_err_t;

    function automatic logic [STAT_W-1:0] err_to_stat(mac_err_t e);
        logic [STAT_W-1:0] r;
        r    = '0;
        r[9] = e.def;
        r[8] = e.hb;
        r[7] = e.lc;
        r[6] = e.rl;
        r[1] = e.un;
        r[0] = e.csl;
        return r;
    endfunction

    function automatic logic [7:0] pick_byte(logic [31:0] w, logic [1:0] lane);
        return w[8*lane +: 8];
    endfunction
endpackage

// File: rtl/txr_demand.sv
module txr_demand (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic go_bit,
    input  logic block,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst || block)
            pend <= 1'b0;
        else if (wr && go_bit)
            pend <= 1'b1;
        else if (take)
            pend <= 1'b0;
    end

    p_halt_drops_dmd_r8: assert property (@(posedge clk) disable iff (rst)
        block |=> !pend);
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int NDESC = 4,
    localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          wrap,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(NDESC - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (adv)
            idx <= (wrap || idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/txr_wb_merge.sv
module txr_wb_merge
    import txr_pkg::*;
(
    input  desc_w0_t    old_w0,
    input  mac_err_t    err,
    output logic [31:0] wdata,
    output logic        fail
);
    desc_w0_t nw;
    always_comb begin
        nw      = old_w0;
        nw.stat = (old_w0.stat & ~(ERR_MASK | (STAT_W'(1) << B_READY))) | err_to_stat(err);
        wdata   = nw;
        fail    = |err;
    end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int NDESC     = 4,
    parameter int AW        = 8,
    parameter int DESC_BASE = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dmd_wr,
    input  logic [15:0]   dmd_data,
    input  logic          restart,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_pad,
    output logic          tx_crc,
    input  logic          mac_done,
    input  logic [5:0]    mac_err,
    output logic [4:0]    evt
);
    localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1;

    state_e        state;
    desc_w0_t      w0;
    logic [AW-1:0] bufa;
    logic [15:0]   cnt;
    logic [31:0]   word;
    mac_err_t      err_q;
    logic [IW-1:0] idx;
    logic          pend, fail, adv, take;
    logic [AW-1:0] dbase;

    assign take  = (state == S_IDLE) && pend;
    assign adv   = (state == S_WB);
    assign dbase = AW'(DESC_BASE) + AW'({idx, 1'b0});

    txr_demand u_dmd (
        .clk(clk), .rst(rst), .wr(dmd_wr), .go_bit(dmd_data[15]),
        .block(state == S_HALT), .take(take), .pend(pend)
    );

    txr_ring_ptr #(.NDESC(NDESC)) u_ptr (
        .clk(clk), .rst(rst), .adv(adv), .wrap(w0.stat[B_WRAP]), .idx(idx)
    );

    txr_wb_merge u_wb (
        .old_w0(w0), .err(err_q), .wdata(mem_wdata), .fail(fail)
    );

    always_comb begin
        mem_rd   = (state == S_D0) || (state == S_D1) || (state == S_BR);
        mem_wr   = (state == S_WB);
        unique case (state)
            S_D1:    mem_addr = dbase + AW'(1);
            S_BR:    mem_addr = bufa + AW'(cnt >> 2);
            default: mem_addr = dbase;
        endcase
        tx_valid = (state == S_OUT);
        tx_data  = pick_byte(word, cnt[1:0]);
        tx_last  = (cnt == w0.len - 16'd1);
        tx_pad   = w0.stat[B_PAD];
        tx_crc   = w0.stat[B_CRC];
        evt          = '0;
        evt[EV_SENT] = (state == S_WB) && !fail;
        evt[EV_ERR]  = (state == S_WB) && fail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            w0    <= '0;
            bufa  <= '0;
            cnt   <= '0;
            word  <= '0;
            err_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (pend) state <= S_D0;
                S_D0:   state <= S_D0W;
                S_D0W: begin
                    w0    <= mem_rdata;
                    state <= mem_rdata[16 + B_READY] ? S_D1 : S_IDLE;
                end
                S_D1:   state <= S_D1W;
                S_D1W: begin
                    bufa  <= mem_rdata[AW-1:0];
                    cnt   <= '0;
                    state <= S_BR;
                end
                S_BR:   state <= S_BRW;
                S_BRW: begin
                    word  <= mem_rdata;
                    state <= S_OUT;
                end
                S_OUT: if (tx_ready) begin
                    cnt <= cnt + 16'd1;
                    if (tx_last)
                        state <= S_WAIT;
                    else if (cnt[1:0] == 2'b11)
                        state <= S_BR;
                end
                S_WAIT: if (mac_done) begin
                    err_q <= mac_err;
                    state <= S_WB;
                end
                S_WB:   state <= fail ? S_HALT : S_D0;
                S_HALT: if (restart) state <= S_D0;
                default: state <= S_IDLE;
            endcase
        end
    end

    p_wb_clears_ready_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_wdata[16 + B_READY]);
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)
                                     && $stable(tx_pad) && $stable(tx_crc)));
    p_last_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);
    p_one_event_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt[EV_ERR], evt[EV_SENT]}));
    p_err_halts_r8: assert property (@(posedge clk) disable iff (rst)
        evt[EV_ERR] |=> (!mem_rd && !mem_wr && !tx_valid));
    p_port_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

// File: tb/sim_txr_engine.sv
module sim_txr_engine;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dmd_wr = 1'b0;
    logic [15:0]   dmd_data = '0;
    logic          restart = 1'b0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          tx_valid, tx_last, tx_pad, tx_crc;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data;
    logic          mac_done = 1'b0;
    logic [5:0]    mac_err = '0;
    logic [4:0]    evt;

    always #5 clk = ~clk;

    txr_engine #(.NDESC(4), .AW(AW), .DESC_BASE(0)) u0 (
        .clk(clk), .rst(rst), .dmd_wr(dmd_wr), .dmd_data(dmd_data), .restart(restart),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_pad(tx_pad), .tx_crc(tx_crc), .mac_done(mac_done),
        .mac_err(mac_err), .evt(evt)
    );

    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    int compared = 0, mismatched = 0;
    int rd_cnt = 0, sent_cnt = 0, err_cnt = 0, rcnt = 0;
    logic [10:0] expq [$];
    logic [5:0]  errq [$];
    logic [15:0] exp_stat [0:3];
    logic [15:0] exp_len  [0:3];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] err_bits(logic [5:0] e);
        logic [15:0] r = '0;
        r[9] = e[5]; r[8] = e[4]; r[7] = e[3]; r[6] = e[2]; r[1] = e[1]; r[0] = e[0];
        return r;
    endfunction

    // driver: lays out a descriptor and pushes its expected bytes
    task automatic push_frame(int idx, int len, bit pad, bit crc, bit wrap, int bufw,
                              logic [5:0] err, logic [15:0] stale);
        logic [15:0] st;
        for (int k = 0; k < len; k++) begin
            logic [7:0] b = 8'((idx * 37 + k * 11 + bufw) & 8'hFF);
            mem[bufw + k / 4][8 * (k % 4) +: 8] = b;
            expq.push_back({(k == len - 1), pad, crc, b});
        end
        st = 16'h8000 | (16'(pad) << 14) | (16'(wrap) << 13) | (16'(crc) << 10) | stale;
        mem[2 * idx]     = {st, 16'(len)};
        mem[2 * idx + 1] = 32'(bufw);
        errq.push_back(err);
        exp_stat[idx] = (st & ~16'h83C3) | err_bits(err);
        exp_len[idx]  = 16'(len);
    endtask

    task automatic demand(logic [15:0] d);
        @(posedge clk); #1 dmd_wr = 1'b1; dmd_data = d;
        @(posedge clk); #1 dmd_wr = 1'b0; dmd_data = '0;
    endtask

    task automatic wait_evt(int ns, int ne);
        while (sent_cnt < ns || err_cnt < ne) @(negedge clk);
    endtask

    task automatic check_desc(int idx, string req);
        check(req, mem[2 * idx], {exp_stat[idx], exp_len[idx]});
    endtask

    // MAC stall pattern
    initial forever begin
        @(posedge clk); #1;
        tx_ready = (rcnt % 3 != 2);
        rcnt++;
    end

    // MAC completion
    initial forever begin
        @(negedge clk);
        if (tx_valid && tx_ready && tx_last) begin
            repeat (3) @(posedge clk);
            #1 mac_err = (errq.size() > 0) ? errq.pop_front() : 6'h0;
            mac_done = 1'b1;
            @(posedge clk); #1 mac_done = 1'b0; mac_err = '0;
        end
    end

    // monitor / scoreboard
    logic       stall_prev = 1'b0;
    logic [7:0] data_prev = '0;
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (mem_rd) rd_cnt++;
            if (evt[1]) sent_cnt++;
            if (evt[4]) err_cnt++;
            if (stall_prev) begin
                check("R5 hold valid", 32'(tx_valid), 32'd1);
                check("R5 hold data", 32'(tx_data), 32'(data_prev));
            end
            if (tx_valid && tx_ready) begin
                if (expq.size() == 0)
                    check("R4 unexpected byte", 32'(tx_data), 32'hFFFF);
                else
                    check("R4 byte", 32'({tx_last, tx_pad, tx_crc, tx_data}),
                          32'(expq.pop_front()));
            end
            stall_prev = tx_valid && !tx_ready;
            data_prev  = tx_data;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int snap;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 mem_rd", 32'(mem_rd), 0);
        check("R1 mem_wr", 32'(mem_wr), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 evt", 32'(evt), 0);

        // three ready frames, the fourth entry not ready
        push_frame(0, 5, 1, 1, 0, 16, 6'h00, 16'h0000);
        push_frame(1, 1, 0, 1, 0, 20, 6'h00, 16'h0001);
        push_frame(2, 8, 1, 0, 0, 24, 6'h00, 16'h0000);

        demand(16'h7FFF);  // R2: bit 15 clear, ignored
        repeat (20) @(negedge clk);
        check("R2 no poll without bit 15", 32'(rd_cnt), 0);
        check("R2 no stream without bit 15", 32'(expq.size()), 14);

        demand(16'h8000);
        wait_evt(3, 0);
        repeat (5) @(negedge clk);
        check_desc(0, "R6 desc0 status");
        check_desc(1, "R6 desc1 stale error cleared");
        check_desc(2, "R6 desc2 status");
        snap = rd_cnt;
        repeat (30) @(negedge clk);
        check("R3 idle after not-ready", 32'(rd_cnt), 32'(snap));
        check("R7 three sent", 32'(sent_cnt), 3);

        // wrap: entry 3 carries wrap bit, then entry 0 again
        push_frame(3, 6, 0, 0, 1, 28, 6'h00, 16'h0000);
        push_frame(0, 4, 0, 1, 0, 36, 6'h00, 16'h0000);
        demand(16'h8000);
        wait_evt(5, 0);
        repeat (30) @(negedge clk);
        check_desc(3, "R7 wrap entry status");
        check_desc(0, "R7 entry after wrap status");
        check("R7 five sent", 32'(sent_cnt), 5);
        check("R4 queue drained", 32'(expq.size()), 0);

        // error then halt
        push_frame(1, 3, 1, 1, 0, 40, 6'b001000, 16'h0000);
        push_frame(2, 2, 0, 1, 0, 44, 6'h00, 16'h0000);
        demand(16'h8000);
        wait_evt(5, 1);
        repeat (5) @(negedge clk);
        check_desc(1, "R8 late collision recorded");
        check("R8 next entry untouched", 32'(mem[4][31]), 1);
        check("R8 no sent event on error", 32'(sent_cnt), 5);
        snap = rd_cnt;
        demand(16'h8000);
        repeat (20) @(negedge clk);
        check("R8 demand ignored while halted", 32'(rd_cnt), 32'(snap));
        check("R8 no stream while halted", 32'(expq.size()), 2);
        @(posedge clk); #1 restart = 1'b1;
        @(posedge clk); #1 restart = 1'b0;
        wait_evt(6, 1);
        repeat (30) @(negedge clk);
        check_desc(2, "R8 resumed entry status");
        check("R4 final queue drained", 32'(expq.size()), 0);
        check("R8 error count", 32'(err_cnt), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule